// File: doc/BRIEF.md
# Serial Register Port with Burst Access

This block is a serial control slave that gives an external host read and write access to a bank of 8-bit configuration registers. The host drives four wires: an active-low select, a serial clock, serial data into the block, and serial data out of the block. Each access opens with a seven-bit register address and a direction flag. Eight data bits follow. If the host keeps select low after the first byte, the block moves on to the next register on its own and keeps transferring bytes for as long as the host keeps clocking.

The block samples the serial wires with its own system clock. It synchronises them and detects their edges, so the whole design runs in one clock domain. The register bank is inside the block. The rest of the chip reads it through a combinational parallel port. Every byte stored from the serial side also appears for one cycle on a write strobe, together with its address and data.

Top module: `spi_regport`

## Requirements
- R1: After reset every register reads 0, `ser_dout` is 0 and `reg_wr_stb` is 0.
- R2: A frame is sampled on rising serial-clock edges, MSB first: 7 address bits, then the direction bit, then 8 data bits. A direction bit of 0 stores the byte at that address. Each stored byte gives exactly one `reg_wr_stb` pulse carrying the address and the byte.
- R3: A direction bit of 1 sends the addressed register out on `ser_dout`, MSB first. The line changes after each falling serial-clock edge, so every bit is valid at the rising edge that follows. The first bit is valid at the first rising edge after the direction bit.
- R4: During a read, the data bits the host sends in are ignored: no register changes and no strobe is produced.
- R5: If select stays low after a write byte, each further group of 8 bits is stored at the previous address plus one.
- R6: If select stays low after a read byte, the register at the previous address plus one follows on the next 8 clocks, with no gap.
- R7: In a burst the 7-bit address wraps from 127 to 0.
- R8: Raising select in the middle of a frame ends it. A partial byte is never stored, and the next select-low period starts a new frame at the address phase.
- R9: `ser_dout` is 0 outside the data phase of a read, and it is 0 again once select is high.
- R10: `par_data` shows the register chosen by `par_addr` with no clock delay. A byte being stored appears there in the cycle after its strobe; in the strobe cycle the old value is still shown.
- R11: `reg_wr_stb` is never high in two consecutive cycles, and it is only high while select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low frame select from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data to the host |
| par_addr | input | 7 | Parallel read port address |
| par_data | output | 8 | Parallel read port data |
| reg_wr_stb | output | 1 | One-cycle pulse per stored byte |
| reg_wr_addr | output | 7 | Address of the stored byte |
| reg_wr_data | output | 8 | Value of the stored byte |

## Verification
Two things can happen in the same system cycle: the serial side commits a byte into the bank, and the parallel port reads that same register. The bench points `par_addr` at the target before each single and burst write. This makes the commit and the parallel read meet at the strobe cycle. On every strobe the monitor checks that `par_data` still holds the old value in that cycle and shows the new byte in the next one. It computes both values from its own copy of the bank.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  // Phase of the serial frame
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DIR  = 2'd1,
    PH_DATA = 2'd2
  } frame_phase_t;

  // Reset value of the synchronised {select, clock, data} bundle
  localparam logic [2:0] SER_IDLE = 3'b100;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int         STAGES = 2,
  parameter int         W      = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/spi_regport_edge.sv
module spi_regport_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;

endmodule

// File: rtl/spi_regport_engine.sv
module spi_regport_engine
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              din_s,
  input  logic              bit_rise,
  input  logic              bit_fall,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sdo,
  output logic              byte_done,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int MAXW  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXW);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;  // modulo 2**ADDR_W
  endfunction

  frame_phase_t      phase;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;
  logic              is_rd;
  logic [DATA_W-2:0] rx;
  logic [DATA_W-1:0] tx;

  // Bank address: current register at the direction bit, next one at a byte end
  assign rd_addr   = (phase == PH_DIR) ? addr : addr_step(addr);
  assign byte_done = bit_rise && !sel_s && (phase == PH_DATA) && (cnt == DATA_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_ADDR;
      cnt   <= '0;
      addr  <= '0;
      is_rd <= 1'b0;
      rx    <= '0;
      tx    <= '0;
      sdo   <= 1'b0;
    end else if (sel_s) begin
      phase <= PH_ADDR;
      cnt   <= '0;
      is_rd <= 1'b0;
      sdo   <= 1'b0;
    end else begin
      if (bit_rise) begin
        unique case (phase)
          PH_ADDR: begin
            addr <= {addr[ADDR_W-2:0], din_s};
            if (cnt == ADDR_LAST) begin
              phase <= PH_DIR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DIR: begin
            is_rd <= din_s;
            phase <= PH_DATA;
            cnt   <= '0;
            if (din_s) tx <= rd_data;
          end
          PH_DATA: begin
            rx <= {rx[DATA_W-3:0], din_s};
            if (cnt == DATA_LAST) begin
              cnt  <= '0;
              addr <= addr_step(addr);
              if (is_rd) tx <= rd_data;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: phase <= PH_ADDR;
        endcase
      end
      if (bit_fall && (phase == PH_DATA) && is_rd) begin
        sdo <= tx[DATA_W-1];
        tx  <= {tx[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= byte_done && !is_rd;
      if (byte_done && !is_rd) begin
        wr_addr <= addr;
        wr_data <= {rx, din_s};
      end
    end
  end

endmodule

// File: rtl/spi_regport_bank.sv
module spi_regport_bank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);

  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = regs[rd_addr_a];
  assign rd_data_b = regs[rd_addr_b];

endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_sel_n,
  input  logic              ser_din,
  output logic              ser_dout,
  input  logic [ADDR_W-1:0] par_addr,
  output logic [DATA_W-1:0] par_data,
  output logic              reg_wr_stb,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data
);

  logic [2:0]        ser_sync;
  logic              sel_sync;
  logic              clk_sync;
  logic              din_sync;
  logic              bit_rise;
  logic              bit_fall;
  logic              byte_done;
  logic [ADDR_W-1:0] ser_rd_addr;
  logic [DATA_W-1:0] ser_rd_data;

  spi_regport_sync #(
    .STAGES (SYNC_STAGES),
    .W      (3),
    .INIT   (SER_IDLE)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_sel_n, ser_clk, ser_din}),
    .sync_out (ser_sync)
  );

  assign sel_sync = ser_sync[2];
  assign clk_sync = ser_sync[1];
  assign din_sync = ser_sync[0];

  spi_regport_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (clk_sync),
    .rise  (bit_rise),
    .fall  (bit_fall)
  );

  spi_regport_engine #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_sync),
    .din_s     (din_sync),
    .bit_rise  (bit_rise),
    .bit_fall  (bit_fall),
    .rd_data   (ser_rd_data),
    .rd_addr   (ser_rd_addr),
    .sdo       (ser_dout),
    .byte_done (byte_done),
    .wr_stb    (reg_wr_stb),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data)
  );

  spi_regport_bank #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_stb),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .rd_addr_a (ser_rd_addr),
    .rd_data_a (ser_rd_data),
    .rd_addr_b (par_addr),
    .rd_data_b (par_data)
  );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_sync,
  input logic              bit_rise,
  input logic              ser_dout,
  input logic              reg_wr_stb,
  input logic [ADDR_W-1:0] reg_wr_addr,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic [ADDR_W-1:0] par_addr,
  input logic [DATA_W-1:0] par_data
);

  logic              have_last;
  logic [ADDR_W-1:0] last_addr;
  logic [ADDR_W-1:0] want_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_addr <= '0;
    end else if (sel_sync) begin
      have_last <= 1'b0;
    end else if (reg_wr_stb) begin
      have_last <= 1'b1;
      last_addr <= reg_wr_addr;
    end
  end

  assign want_addr = last_addr + 1'b1;

  assert_stb_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |-> $past(bit_rise));

  // R5 and R7: burst writes step the address by one, wrapping
  assert_burst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_stb && have_last) |-> (reg_wr_addr == want_addr));

  assert_dout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sync |=> (ser_dout == 1'b0));

  assert_write_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |=> ((par_addr != $past(reg_wr_addr)) || (par_data == $past(reg_wr_data))));

  assert_stb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |=> !reg_wr_stb);

  assert_stb_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |-> !$past(sel_sync));

endmodule

bind spi_regport spi_regport_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_sync    (sel_sync),
  .bit_rise    (bit_rise),
  .ser_dout    (ser_dout),
  .reg_wr_stb  (reg_wr_stb),
  .reg_wr_addr (reg_wr_addr),
  .reg_wr_data (reg_wr_data),
  .par_addr    (par_addr),
  .par_data    (par_data)
);

// File: tb/spi_regport_test.sv
module spi_regport_test;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_clk, ser_sel_n, ser_din;
  logic       ser_dout;
  logic [6:0] par_addr;
  logic [7:0] par_data;
  logic       reg_wr_stb;
  logic [6:0] reg_wr_addr;
  logic [7:0] reg_wr_data;

  always #4 clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .par_addr(par_addr),
    .par_data(par_data), .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data)
  );

  typedef struct packed { logic [6:0] a; logic [7:0] d; } wr_item_t;

  int       checks = 0;
  int       fails  = 0;
  bit       done   = 0;
  wr_item_t exp_wr_q[$];
  logic [7:0] drv_model [128];
  logic [7:0] mon_model [128];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: pops expected writes, judges the parallel port around each strobe
  logic       prev_stb  = 1'b0;
  logic       post_chk  = 1'b0;
  logic [6:0] post_addr;
  logic [7:0] post_data;

  always @(negedge clk) begin
    if (rst_n) begin
      if (post_chk) begin
        post_chk = 1'b0;
        if (par_addr == post_addr) chk(par_data == post_data, "R10 new value", par_data, post_data);
      end
      if (reg_wr_stb) begin
        chk(!prev_stb, "R11 strobe width", 32'(prev_stb), 0);
        if (exp_wr_q.size() == 0) begin
          chk(1'b0, "R8/R4 unexpected write", reg_wr_addr, 0);
        end else begin
          wr_item_t it;
          it = exp_wr_q.pop_front();
          chk(reg_wr_addr == it.a, "R2/R5 write address", reg_wr_addr, it.a);
          chk(reg_wr_data == it.d, "R2/R5 write data", reg_wr_data, it.d);
        end
        if (par_addr == reg_wr_addr)
          chk(par_data == mon_model[reg_wr_addr], "R10 old value", par_data, mon_model[reg_wr_addr]);
        mon_model[reg_wr_addr] = reg_wr_data;
        post_chk  = 1'b1;
        post_addr = reg_wr_addr;
        post_data = reg_wr_data;
      end
      prev_stb = reg_wr_stb;
    end
  end

  task automatic xfer_bit(input logic d, output logic q);
    ser_din = d;
    repeat (HALF) @(negedge clk);
    q = ser_dout;
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic sel_low();
    ser_sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_high();
    repeat (HALF) @(negedge clk);
    ser_sel_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic header(input logic [6:0] a, input logic rw);
    logic q;
    for (int i = 6; i >= 0; i--) begin
      xfer_bit(a[i], q);
      chk(q == 1'b0, "R9 dout in address phase", q, 0);
    end
    xfer_bit(rw, q);
    chk(q == 1'b0, "R9 dout at direction bit", q, 0);
  endtask

  task automatic write_frame(input logic [6:0] a, input logic [7:0] d [4], input int n);
    logic q;
    logic [6:0] cur;
    cur = a;
    for (int k = 0; k < n; k++) begin
      exp_wr_q.push_back({cur, d[k]});
      drv_model[cur] = d[k];
      cur = cur + 7'd1;
    end
    sel_low();
    header(a, 1'b0);
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) begin
        xfer_bit(d[k][i], q);
        chk(q == 1'b0, "R9 dout during write", q, 0);
      end
    sel_high();
  endtask

  task automatic read_frame(input logic [6:0] a, input int n, input string req);
    logic q;
    logic [7:0] got;
    logic [6:0] cur;
    cur = a;
    sel_low();
    header(a, 1'b1);
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        xfer_bit(1'b1, q);  // input bits ignored during a read
        got[i] = q;
      end
      chk(got == drv_model[cur], req, got, drv_model[cur]);
      cur = cur + 7'd1;
    end
    sel_high();
    chk(ser_dout == 1'b0, "R9 dout after read", ser_dout, 0);
  endtask

  task automatic abort_frame(input logic [6:0] a, input logic [7:0] d, input int nbits);
    logic q;
    sel_low();
    header(a, 1'b0);
    for (int i = 7; i > 7 - nbits; i--) xfer_bit(d[i], q);
    sel_high();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: all requirements, actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      drv_model[i] = 8'h00;
      mon_model[i] = 8'h00;
    end
    rst_n = 1'b0; ser_clk = 1'b0; ser_sel_n = 1'b1; ser_din = 1'b0; par_addr = 7'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(ser_dout == 1'b0, "R1 dout", ser_dout, 0);
    chk(reg_wr_stb == 1'b0, "R1 strobe", reg_wr_stb, 0);
    chk(par_data == 8'h00, "R1 reg 0", par_data, 0);
    par_addr = 7'h7F; #1;
    chk(par_data == 8'h00, "R1 reg 127", par_data, 0);

    // R2 single write, colliding with the parallel read of the same register
    par_addr = 7'h12;
    write_frame(7'h12, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1);
    chk(par_data == 8'hA5, "R2 stored value", par_data, 8'hA5);

    // R3 single read; R4 the ones sent during the read change nothing
    read_frame(7'h12, 1, "R3 read byte");
    chk(par_data == 8'hA5, "R4 register unchanged by read", par_data, 8'hA5);

    // R5 and R7 burst write across the wrap
    par_addr = 7'h7F;
    write_frame(7'h7E, '{8'h3C, 8'hC3, 8'h5A, 8'h00}, 3);
    chk(par_data == 8'hC3, "R5 burst second register", par_data, 8'hC3);
    par_addr = 7'h00; #1;
    chk(par_data == 8'h5A, "R7 wrapped register 0", par_data, 8'h5A);

    // R6 and R7 burst read across the wrap
    read_frame(7'h7E, 3, "R6/R7 burst read byte");

    // R8 abort in the middle of the data byte
    par_addr = 7'h12;
    abort_frame(7'h12, 8'h0F, 4);
    chk(par_data == 8'hA5, "R8 partial byte not stored", par_data, 8'hA5);
    chk(ser_dout == 1'b0, "R9 dout after abort", ser_dout, 0);

    // R8 next frame starts clean
    par_addr = 7'h20;
    write_frame(7'h20, '{8'h99, 8'h66, 8'h00, 8'h00}, 2);
    chk(par_data == 8'h99, "R8 fresh frame after abort", par_data, 8'h99);
    read_frame(7'h20, 2, "R6 burst read after abort");

    repeat (10) @(negedge clk);
    chk(exp_wr_q.size() == 0, "R2 all expected writes seen", exp_wr_q.size(), 0);

    done = 1;
    report();
    $finish;
  end

endmodule